// File: doc/BRIEF.md
# Serial Dual-Channel Converter Command Register

This block is the digital front end of a two-channel, 10-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial link: an active-low select/load strobe, a serial clock and a data line. All three are brought into the system clock domain through synchronisers, and a bit is taken on each synchronised rising edge of the serial clock while the strobe is low. When the strobe returns high, the word held in the shift register is decoded and carried out.

Each channel holds two registers. The input register takes new codes. The converter register drives the analog stage. A 4-bit command can load either input register or both, copy both input registers into both converter registers at the same time, wake the converter, or put it to sleep. Sleep keeps every register and marks both outputs as high-impedance. The input registers can still be loaded while the block sleeps, so a single later command can wake the converter and update both outputs.

Top module: `sdac_cmd_top`

## Requirements
- R1: A word is 16 bits, sent most significant bit first: the 4-bit command in bits 15..12, the 10-bit code in bits 11..2, and two ignored bits in bits 1..0.
- R2: Serial clock edges are ignored while the strobe is high; they neither shift data nor cause a command to run.
- R3: A command runs only on a rising edge of the strobe. Between commands, no input register, converter register or power state changes.
- R4: Command 0001 loads the code into input register A, and 0010 loads it into input register B. Neither command changes the converter registers or the power state.
- R5: Command 1000 copies both input registers into both converter registers and wakes the block.
- R6: Command 1001 loads input A with the code and then updates both converter registers. Command 1010 does the same with input B. Both commands wake the block.
- R7: Command 1111 loads the code into both input registers, updates both converter registers and wakes the block.
- R8: Command 1101 only wakes the block. Command 1110 only puts it to sleep, and the code field of 1110 has no effect.
- R9: Command 0000 and the reserved commands 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change no register and no power state.
- R10: While asleep, asleep is 1 and both output enables are 0, and all registers keep their values. Input registers can still be loaded during sleep. While awake, both output enables are 1.
- R11: Reset clears all four registers to zero and leaves the block awake.
- R12: If the strobe rises after other than 16 clocks, the last 16 bits held in the shift register are decoded. A strobe pulse with no clock edges runs no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Serial select (low) and load strobe (rising edge) |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, taken on the rising serial clock edge |
| dac_a | output | 10 | Converter register of channel A |
| dac_b | output | 10 | Converter register of channel B |
| asleep | output | 1 | Power state: 1 while asleep |
| out_en_a | output | 1 | Output enable of channel A (0 means high-impedance) |
| out_en_b | output | 1 | Output enable of channel B (0 means high-impedance) |

## Verification
The assertions assume that each serial level lasts several system clock cycles, so that every edge of the serial clock and of the strobe is seen once after synchronisation. They also assume that the data line is steady around each rising edge of the serial clock. The stimulus holds every serial level for four system cycles, changes data only while the serial clock is low, and changes the strobe only while the serial clock is low. After each strobe rise, the bench waits ten system cycles before it compares all outputs with values computed from the command sequence.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Command codes carried in the top nibble of a serial word
    typedef enum logic [3:0] {
        CMD_NOP      = 4'b0000,
        CMD_LD_A     = 4'b0001,
        CMD_LD_B     = 4'b0010,
        CMD_UPD      = 4'b1000,
        CMD_LD_A_UPD = 4'b1001,
        CMD_LD_B_UPD = 4'b1010,
        CMD_WAKE     = 4'b1101,
        CMD_SLEEP    = 4'b1110,
        CMD_LD_ALL   = 4'b1111
    } sdac_cmd_e;

    // Decoded actions of one command
    typedef struct packed {
        logic ld_a;
        logic ld_b;
        logic upd;
        logic wake;
        logic sleep;
    } sdac_act_t;

    function automatic sdac_act_t sdac_decode(input logic [3:0] code);
        sdac_act_t a;
        a = '0;
        case (code)
            CMD_LD_A:     a.ld_a = 1'b1;
            CMD_LD_B:     a.ld_b = 1'b1;
            CMD_UPD:      begin a.upd = 1'b1; a.wake = 1'b1; end
            CMD_LD_A_UPD: begin a.ld_a = 1'b1; a.upd = 1'b1; a.wake = 1'b1; end
            CMD_LD_B_UPD: begin a.ld_b = 1'b1; a.upd = 1'b1; a.wake = 1'b1; end
            CMD_WAKE:     a.wake = 1'b1;
            CMD_SLEEP:    a.sleep = 1'b1;
            CMD_LD_ALL:   begin a.ld_a = 1'b1; a.ld_b = 1'b1; a.upd = 1'b1; a.wake = 1'b1; end
            default:      a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sdac_serial_rx.sv
module sdac_serial_rx #(
    parameter int WORD_W      = 16,
    parameter int KEEP_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdat,
    output logic [KEEP_W-1:0] field,
    output logic              exec
);
    logic [SYNC_STAGES:0]   sclk_q;
    logic [SYNC_STAGES:0]   sel_q;
    logic [SYNC_STAGES-1:0] dat_q;
    logic [WORD_W-1:0]      shreg;
    logic                   clocked;

    logic sclk_s, sclk_d, sel_s, sel_d, dat_s;
    logic sclk_rise, sel_rise;

    assign sclk_s    = sclk_q[SYNC_STAGES-1];
    assign sclk_d    = sclk_q[SYNC_STAGES];
    assign sel_s     = sel_q[SYNC_STAGES-1];
    assign sel_d     = sel_q[SYNC_STAGES];
    assign dat_s     = dat_q[SYNC_STAGES-1];
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sel_rise  = sel_s & ~sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            sel_q  <= '1;
            dat_q  <= '0;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
            sel_q  <= {sel_q[SYNC_STAGES-1:0], sel_n};
            dat_q  <= {dat_q[SYNC_STAGES-2:0], sdat};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            clocked <= 1'b0;
        end else if (sel_rise) begin
            clocked <= 1'b0;
        end else if (sclk_rise && !sel_s) begin
            shreg   <= {shreg[WORD_W-2:0], dat_s};
            clocked <= 1'b1;
        end
    end

    assign exec  = sel_rise & clocked;
    assign field = shreg[WORD_W-1 -: KEEP_W];

    // R2: with the synchronised strobe high, nothing is shifted in
    assert_no_shift_when_high_R2: assert property (@(posedge clk) disable iff (rst)
        sel_s |=> $stable(shreg));

    // R12: a strobe pulse with no clock edges never triggers a command
    assert_no_exec_without_clock_R12: assert property (@(posedge clk) disable iff (rst)
        (sel_s && sel_d) |=> !exec);

endmodule

// File: rtl/sdac_channel.sv
module sdac_channel #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ld,
    input  logic              upd,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] dac_q
);
    logic [CODE_W-1:0] in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            dac_q <= '0;
        end else if (en) begin
            if (ld)
                in_q <= code;
            if (upd)
                dac_q <= ld ? code : in_q;
        end
    end

    // R3: registers hold between commands
    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(in_q) && $stable(dac_q)));

    // R5: after an update the converter register matches the input register
    assert_update_matches_R5: assert property (@(posedge clk) disable iff (rst)
        (en && upd) |=> (dac_q == in_q));

    // R4: a load without update leaves the converter register alone
    assert_load_only_R4: assert property (@(posedge clk) disable iff (rst)
        (en && ld && !upd) |=> $stable(dac_q));

endmodule

// File: rtl/sdac_power.sv
module sdac_power (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic go_sleep,
    input  logic go_wake,
    output logic asleep
);
    always_ff @(posedge clk) begin
        if (rst)
            asleep <= 1'b0;
        else if (en && go_sleep)
            asleep <= 1'b1;
        else if (en && go_wake)
            asleep <= 1'b0;
    end

    // R3: power state changes only when a command runs
    assert_power_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(asleep));

    // R8: a sleep command always leaves the block asleep
    assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (en && go_sleep) |=> asleep);

endmodule

// File: rtl/sdac_cmd_top.sv
module sdac_cmd_top #(
    parameter int CTRL_W      = 4,
    parameter int CODE_W      = 10,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b,
    output logic              asleep,
    output logic              out_en_a,
    output logic              out_en_b
);
    import sdac_pkg::*;

    localparam int KEEP_W = CTRL_W + CODE_W;
    localparam int WORD_W = KEEP_W + PAD_W;
    localparam int NCH    = 2;

    logic [KEEP_W-1:0]          field;
    logic                       exec;
    logic [CODE_W-1:0]          code;
    sdac_act_t                  act;
    logic [NCH-1:0]             ld_vec;
    logic [NCH-1:0][CODE_W-1:0] dac_vec;

    sdac_serial_rx #(
        .WORD_W      (WORD_W),
        .KEEP_W      (KEEP_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk   (clk),
        .rst   (rst),
        .sel_n (ser_sel_n),
        .sclk  (ser_clk),
        .sdat  (ser_dat),
        .field (field),
        .exec  (exec)
    );

    assign code   = field[CODE_W-1:0];
    assign act    = sdac_decode(field[KEEP_W-1 -: CTRL_W]);
    assign ld_vec = {act.ld_b, act.ld_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        sdac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .en    (exec),
            .ld    (ld_vec[ch]),
            .upd   (act.upd),
            .code  (code),
            .dac_q (dac_vec[ch])
        );
    end

    sdac_power u_pwr (
        .clk      (clk),
        .rst      (rst),
        .en       (exec),
        .go_sleep (act.sleep),
        .go_wake  (act.wake),
        .asleep   (asleep)
    );

    assign dac_a    = dac_vec[0];
    assign dac_b    = dac_vec[1];
    assign out_en_a = ~asleep;
    assign out_en_b = ~asleep;

    // R10: converter registers stay put while asleep unless a waking update runs
    assert_sleep_retains_R10: assert property (@(posedge clk) disable iff (rst)
        (asleep && !exec) |=> ($stable(dac_a) && $stable(dac_b)));

endmodule

// File: tb/sdac_cmd_top_bench.sv
module sdac_cmd_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int SETTLE     = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [3:0] cmd;
        logic [9:0] code;
        logic [9:0] exp_a;
        logic [9:0] exp_b;
        logic       exp_sleep;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{4'b0001, 10'd100,  10'd0,    10'd0,   1'b0}, // R4
        '{4'b0010, 10'd200,  10'd0,    10'd0,   1'b0}, // R4
        '{4'b1000, 10'd7,    10'd100,  10'd200, 1'b0}, // R5
        '{4'b1110, 10'd555,  10'd100,  10'd200, 1'b1}, // R8
        '{4'b0001, 10'd300,  10'd100,  10'd200, 1'b1}, // R10
        '{4'b1000, 10'd0,    10'd300,  10'd200, 1'b0}, // R10 R5
        '{4'b1001, 10'd400,  10'd400,  10'd200, 1'b0}, // R6
        '{4'b1010, 10'd500,  10'd400,  10'd500, 1'b0}, // R6
        '{4'b1111, 10'd1023, 10'd1023, 10'd1023,1'b0}, // R7
        '{4'b0011, 10'd7,    10'd1023, 10'd1023,1'b0}, // R9
        '{4'b1110, 10'd1,    10'd1023, 10'd1023,1'b1}, // R8
        '{4'b0000, 10'd2,    10'd1023, 10'd1023,1'b1}, // R9
        '{4'b1101, 10'd3,    10'd1023, 10'd1023,1'b0}, // R8
        '{4'b0010, 10'd5,    10'd1023, 10'd1023,1'b0}, // R4
        '{4'b1000, 10'd0,    10'd1023, 10'd5,   1'b0}, // R5
        '{4'b0111, 10'd9,    10'd1023, 10'd5,   1'b0}, // R9
        '{4'b1011, 10'd9,    10'd1023, 10'd5,   1'b0}, // R9
        '{4'b1100, 10'd9,    10'd1023, 10'd5,   1'b0}, // R9
        '{4'b0100, 10'd9,    10'd1023, 10'd5,   1'b0}, // R9
        '{4'b1000, 10'd0,    10'd1023, 10'd5,   1'b0}  // R9 via copy
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_sel_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [9:0] dac_a, dac_b;
    logic       asleep, out_en_a, out_en_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_cmd_top u_sdac_cmd_top (
        .clk       (clk),
        .rst       (rst),
        .ser_sel_n (ser_sel_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .dac_a     (dac_a),
        .dac_b     (dac_b),
        .asleep    (asleep),
        .out_en_a  (out_en_a),
        .out_en_b  (out_en_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_state(input string tag, input int ea, input int eb, input int es);
        check({tag, " dac_a"}, int'(dac_a), ea);
        check({tag, " dac_b"}, int'(dac_b), eb);
        check({tag, " asleep"}, int'(asleep), es);
        check({tag, " R10 out_en_a"}, int'(out_en_a), 1 - es);
        check({tag, " R10 out_en_b"}, int'(out_en_b), 1 - es);
    endtask

    // Sends bits[n-1:0] most significant first inside one strobe frame
    task automatic send_bits(input logic [31:0] bits, input int n);
        ser_sel_n = 1'b0;
        tick(HOLD);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            tick(HOLD);
            ser_clk = 1'b1;
            tick(HOLD);
            ser_clk = 1'b0;
        end
        tick(HOLD);
        ser_sel_n = 1'b1;
        tick(SETTLE);
    endtask

    task automatic send_cmd(input logic [3:0] cmd, input logic [9:0] code);
        send_bits({16'h0, cmd, code, 2'b00}, 16);
    endtask

    initial begin
        tick(WATCHDOG);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R11: reset state
        check_state("R11 reset", 0, 0, 0);

        // R1 R3 and command table
        for (int v = 0; v < NVEC; v++) begin
            send_cmd(VEC[v].cmd, VEC[v].code);
            check_state($sformatf("R1 R3 vec%0d", v), int'(VEC[v].exp_a),
                        int'(VEC[v].exp_b), int'(VEC[v].exp_sleep));
        end

        // R2: clock edges with the strobe high are ignored
        ser_dat = 1'b1;
        for (int i = 0; i < 16; i++) begin
            tick(HOLD);
            ser_clk = 1'b1;
            tick(HOLD);
            ser_clk = 1'b0;
        end
        ser_dat = 1'b0;
        tick(SETTLE);
        check_state("R2 clocks while high", 1023, 5, 0);

        // R12: strobe pulse with no clocks runs nothing
        send_bits(32'h0, 0);
        check_state("R12 empty strobe", 1023, 5, 0);
        send_cmd(4'b1000, 10'd0);
        check_state("R2 shift untouched", 1023, 5, 0);

        // R12: 20 clocks, last 16 decoded (load both with 88)
        send_bits({12'h0, 4'b1010, 4'b1111, 10'd88, 2'b00}, 20);
        check_state("R12 long frame", 88, 88, 0);

        // R12: 4 clocks shift onto held word -> command 0001, code 384
        send_bits(32'h0, 4);
        check_state("R12 short frame", 88, 88, 0);
        send_cmd(4'b1000, 10'd0);
        check_state("R12 short frame load", 384, 88, 0);

        // R11: reset again mid-run
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        check_state("R11 re-reset", 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule